// File: doc/BRIEF.md
# Byte-Serial Counter Register Interface

This block is the host-facing register front end for a single 24-bit counter channel. A host reaches it through two byte-wide ports chosen by one select line: a data port and a control/status port. On the data port, successive writes fill a 24-bit preset word and successive reads drain a 24-bit output latch. Both use one shared byte pointer that starts at the least significant byte, moves up one byte per access and wraps back after the top byte. On the control port, a write is a command byte whose bits 6:5 pick a family: reset/load, mode, I/O control or index control. A read returns a status byte.

The counting engine sits outside this block. The front end gives it a one-cycle load strobe together with the preset word. It also sends a snapshot pulse each time the latch captures the engine's count, plus the configuration fields held in three small registers. It keeps the sticky event flags that the engine raises through one-cycle event pulses.

The byte pointer is a three-state machine. PTR_LO goes to PTR_MID, PTR_MID goes to PTR_HI, and PTR_HI wraps to PTR_LO, each on a data-port access (step). Every state goes to PTR_LO on a rewind command. With neither event the state holds.

Top module: `qc_counter_regif`

## Requirements
- R1: After reset the pointer is at byte 0, preset, latch and all flags are zero, and every configuration output is 0 (binary, normal count, non-quadrature, A/B disabled, preset-on-index allowed, aux select 0, index disabled, negative polarity).
- R2: A data-port write (host_sel_ctrl=0, host_wr=1) stores host_wdata into the preset byte the pointer selects, least significant byte first. The pointer then advances 0→1→2→0, so a fourth write lands in byte 0 again.
- R3: A data-port read (host_rd=1, host_wr=0) returns the latch byte the pointer selects and advances the pointer with the same wrap. Reads never raise core_load and never change the preset.
- R4: A reset/load-family control byte (bits 6:5 = 00) with bit 0 set (e.g. 0x01) returns the pointer to byte 0.
- R5: A reset/load-family control byte with bit 4 set copies core_count into the latch at that clock edge and pulses core_snap for the next cycle. 0x11 also rewinds the pointer, and 0x10 leaves the pointer where it is.
- R6: A reset/load-family control byte with bit 3 set (0x08) raises core_load for exactly the following cycle, with core_load_value equal to the preset.
- R7: Event pulses set sticky flags. In the reset/load family, bits 2:1 = 01 or 10 (0x02, 0x04) clear borrow, carry, compare and sign, and bits 2:1 = 11 (0x06) clears only error. An event in the same cycle as a clear leaves its flag set.
- R8: A control-port read returns status with bit0 borrow, bit1 carry, bit2 compare, bit3 sign, bit4 error, bit5 core_dir_up, bit6 core_index_lvl, bit7 0.
- R9: A mode-family byte (bits 6:5 = 01, e.g. 0x20|cfg) loads cfg_bcd_en from bit 0, cfg_count_mode from bits 2:1 and cfg_quad_mode from bits 4:3. No other control byte changes these fields.
- R10: An I/O-family byte (bits 6:5 = 10, 0x40|cfg) loads cfg_ab_en from bit 0, cfg_idx_preset_off from bit 1 and cfg_aux_sel from bits 4:3. Bit 2 is ignored.
- R11: An index-family byte (bits 6:5 = 11, 0x60|cfg) loads cfg_idx_en from bit 0 and cfg_idx_pos from bit 1.
- R12: Control-port writes and status reads neither move the pointer (except through R4/R5) nor alter the preset. Bit 7 of a control byte is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel_ctrl | input | 1 | 1 selects control/status port, 0 data port |
| host_wr | input | 1 | Host write strobe (wins over host_rd) |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Latch byte or status byte, combinational |
| core_count | input | 24 | Live count from the counting engine |
| core_dir_up | input | 1 | Engine counting upward |
| core_index_lvl | input | 1 | Level of the index input |
| core_borrow_evt | input | 1 | Borrow event pulse |
| core_carry_evt | input | 1 | Carry event pulse |
| core_compare_evt | input | 1 | Compare-match event pulse |
| core_sign_evt | input | 1 | Sign event pulse |
| core_error_evt | input | 1 | Input-noise error event pulse |
| core_load | output | 1 | One-cycle preset-to-counter strobe |
| core_load_value | output | 24 | Preset word |
| core_snap | output | 1 | One-cycle pulse after a latch capture |
| cfg_bcd_en | output | 1 | Decimal count encoding |
| cfg_count_mode | output | 2 | Count mode select |
| cfg_quad_mode | output | 2 | Quadrature mode select (00 non-quadrature) |
| cfg_ab_en | output | 1 | A/B input enable |
| cfg_idx_preset_off | output | 1 | Disable preset on index |
| cfg_aux_sel | output | 2 | Auxiliary flag output function |
| cfg_idx_en | output | 1 | Index function enable |
| cfg_idx_pos | output | 1 | Positive index polarity |

## Verification
The checker covers the cycle-local properties on every cycle. The pointer never takes the unused encoding, and a rewind always lands on byte 0. Every load strobe traces back to a 0x08-type write one cycle earlier, and reads never raise a load. A snapshot pulse always matches the captured latch word. Borrow stays raised after its event. Mode fields and the preset hold unless their own write happens. Multi-byte behaviour can only be shown by the directed scenarios: byte order, pointer wrap across four accesses, and a snapshot taken without a rewind. The same holds for the clear-family split between status and error, the priority of a set over a simultaneous clear, and the layout of the status byte.

// File: rtl/qc_regif_pkg.sv
package qc_regif_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 3;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int PTR_W      = $clog2(WORD_BYTES);
    localparam int NUM_FLAGS  = 5;
    localparam int FLAG_ERR   = 4;
    localparam int FIELD_W    = 5;
    localparam int CTRL_W     = 7;

    typedef enum logic [1:0] {
        FAM_RESET_LOAD = 2'b00,
        FAM_MODE       = 2'b01,
        FAM_IOCTL      = 2'b10,
        FAM_INDEX      = 2'b11
    } fam_t;

    typedef enum logic [PTR_W-1:0] {
        PTR_LO  = 2'd0,
        PTR_MID = 2'd1,
        PTR_HI  = 2'd2
    } ptr_state_t;

    typedef struct packed {
        logic               rewind;
        logic               snap;
        logic               load;
        logic               clr_status;
        logic               clr_error;
        logic               wr_mode;
        logic               wr_ioctl;
        logic               wr_index;
        logic [FIELD_W-1:0] field;
    } ctrl_cmd_t;
endpackage

// File: rtl/qc_ctrl_decode.sv
module qc_ctrl_decode
    import qc_regif_pkg::*;
(
    input  logic              strobe,
    input  logic [CTRL_W-1:0] ctrl_byte,
    output ctrl_cmd_t         cmd
);
    fam_t fam;
    assign fam = fam_t'(ctrl_byte[6:5]);

    always_comb begin
        cmd       = '0;
        cmd.field = ctrl_byte[FIELD_W-1:0];
        if (strobe) begin
            unique case (fam)
                FAM_RESET_LOAD: begin
                    cmd.rewind     = ctrl_byte[0];
                    cmd.clr_status = (ctrl_byte[2:1] == 2'b01) || (ctrl_byte[2:1] == 2'b10);
                    cmd.clr_error  = (ctrl_byte[2:1] == 2'b11);
                    cmd.load       = ctrl_byte[3];
                    cmd.snap       = ctrl_byte[4];
                end
                FAM_MODE:  cmd.wr_mode  = 1'b1;
                FAM_IOCTL: cmd.wr_ioctl = 1'b1;
                FAM_INDEX: cmd.wr_index = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/qc_byte_ptr.sv
module qc_byte_ptr
    import qc_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             rewind,
    output logic [PTR_W-1:0] idx
);
    ptr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (rewind) begin
            state_d = PTR_LO;
        end else if (step) begin
            unique case (state_q)
                PTR_LO:  state_d = PTR_MID;
                PTR_MID: state_d = PTR_HI;
                PTR_HI:  state_d = PTR_LO;
                default: state_d = PTR_LO;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            PTR_LO:  idx = 2'd0;
            PTR_MID: idx = 2'd1;
            PTR_HI:  idx = 2'd2;
            default: idx = 2'd0;
        endcase
    end
endmodule

// File: rtl/qc_flag_bank.sv
module qc_flag_bank
    import qc_regif_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clr_status,
    input  logic         clr_error,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr_i;
        logic q;
        if (i == FLAG_ERR) begin : g_err
            assign clr_i = clr_error;
        end else begin : g_stat
            assign clr_i = clr_status;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q <= 1'b0;
            else if (set_evt[i]) q <= 1'b1;
            else if (clr_i)      q <= 1'b0;
        end
        assign flags[i] = q;
    end
endmodule

// File: rtl/qc_counter_regif.sv
module qc_counter_regif
    import qc_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_ctrl,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic [WORD_W-1:0] core_count,
    input  logic              core_dir_up,
    input  logic              core_index_lvl,
    input  logic              core_borrow_evt,
    input  logic              core_carry_evt,
    input  logic              core_compare_evt,
    input  logic              core_sign_evt,
    input  logic              core_error_evt,
    output logic              core_load,
    output logic [WORD_W-1:0] core_load_value,
    output logic              core_snap,
    output logic              cfg_bcd_en,
    output logic [1:0]        cfg_count_mode,
    output logic [1:0]        cfg_quad_mode,
    output logic              cfg_ab_en,
    output logic              cfg_idx_preset_off,
    output logic [1:0]        cfg_aux_sel,
    output logic              cfg_idx_en,
    output logic              cfg_idx_pos
);
    logic data_wr, data_rd, ctrl_wr;
    assign data_wr = host_wr && !host_sel_ctrl;
    assign data_rd = host_rd && !host_wr && !host_sel_ctrl;
    assign ctrl_wr = host_wr && host_sel_ctrl;

    ctrl_cmd_t cmd;
    qc_ctrl_decode u_dec (
        .strobe    (ctrl_wr),
        .ctrl_byte (host_wdata[CTRL_W-1:0]),
        .cmd       (cmd)
    );

    logic [PTR_W-1:0] ptr_idx;
    qc_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (data_wr | data_rd),
        .rewind (cmd.rewind),
        .idx    (ptr_idx)
    );

    logic [NUM_FLAGS-1:0] flags;
    qc_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_evt    ({core_error_evt, core_sign_evt, core_compare_evt,
                      core_carry_evt, core_borrow_evt}),
        .clr_status (cmd.clr_status),
        .clr_error  (cmd.clr_error),
        .flags      (flags)
    );

    // Preset word: one byte lane per pointer position
    logic [WORD_BYTES-1:0][BYTE_W-1:0] preset_q;
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_preset
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                preset_q[b] <= '0;
            else if (data_wr && (ptr_idx == PTR_W'(b)))
                preset_q[b] <= host_wdata;
        end
    end

    // Output latch, captured whole on a snapshot command
    logic [WORD_BYTES-1:0][BYTE_W-1:0] latch_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        latch_q <= '0;
        else if (cmd.snap) latch_q <= core_count;
    end

    // Strobes to the counting engine
    logic load_q, snap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= 1'b0;
            snap_q <= 1'b0;
        end else begin
            load_q <= cmd.load;
            snap_q <= cmd.snap;
        end
    end

    // Configuration registers
    logic       bcd_q, ab_q, poff_q, idx_en_q, idx_pos_q;
    logic [1:0] cmode_q, qmode_q, aux_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcd_q     <= 1'b0;
            cmode_q   <= 2'b00;
            qmode_q   <= 2'b00;
            ab_q      <= 1'b0;
            poff_q    <= 1'b0;
            aux_q     <= 2'b00;
            idx_en_q  <= 1'b0;
            idx_pos_q <= 1'b0;
        end else begin
            if (cmd.wr_mode) begin
                bcd_q   <= cmd.field[0];
                cmode_q <= cmd.field[2:1];
                qmode_q <= cmd.field[4:3];
            end
            if (cmd.wr_ioctl) begin
                ab_q   <= cmd.field[0];
                poff_q <= cmd.field[1];
                aux_q  <= cmd.field[4:3];
            end
            if (cmd.wr_index) begin
                idx_en_q  <= cmd.field[0];
                idx_pos_q <= cmd.field[1];
            end
        end
    end

    // Read mux
    logic [BYTE_W-1:0] status_byte;
    assign status_byte = {1'b0, core_index_lvl, core_dir_up, flags};

    always_comb begin
        if (host_sel_ctrl) begin
            host_rdata = status_byte;
        end else begin
            unique case (ptr_idx)
                2'd1:    host_rdata = latch_q[1];
                2'd2:    host_rdata = latch_q[2];
                default: host_rdata = latch_q[0];
            endcase
        end
    end

    assign core_load          = load_q;
    assign core_load_value    = preset_q;
    assign core_snap          = snap_q;
    assign cfg_bcd_en         = bcd_q;
    assign cfg_count_mode     = cmode_q;
    assign cfg_quad_mode      = qmode_q;
    assign cfg_ab_en          = ab_q;
    assign cfg_idx_preset_off = poff_q;
    assign cfg_aux_sel        = aux_q;
    assign cfg_idx_en         = idx_en_q;
    assign cfg_idx_pos        = idx_pos_q;
endmodule

// File: rtl/qc_regif_checker.sv
module qc_regif_checker
    import qc_regif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel_ctrl,
    input logic              host_wr,
    input logic              host_rd,
    input logic [1:0]        ctrl_fam,
    input logic              ctrl_b0,
    input logic              ctrl_b3,
    input logic [WORD_W-1:0] core_count,
    input logic              core_borrow_evt,
    input logic              core_load,
    input logic              core_snap,
    input logic [PTR_W-1:0]  ptr_idx,
    input logic [WORD_W-1:0] latch_word,
    input logic [WORD_W-1:0] preset_word,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [4:0]        mode_bits
);
    p_ptr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_idx != 2'd3);

    p_read_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> !core_load);

    p_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel_ctrl && ctrl_fam == 2'b00 && ctrl_b0) |=> ptr_idx == '0);

    p_snap_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_snap |-> latch_word == $past(core_count));

    p_load_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_load |-> $past(host_wr && host_sel_ctrl && ctrl_fam == 2'b00 && ctrl_b3));

    p_borrow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_borrow_evt |=> flags[0]);

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_sel_ctrl && ctrl_fam == 2'b01) |=> $stable(mode_bits));

    p_preset_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && !host_sel_ctrl) |=> $stable(preset_word));
endmodule

bind qc_counter_regif qc_regif_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_sel_ctrl   (host_sel_ctrl),
    .host_wr         (host_wr),
    .host_rd         (host_rd),
    .ctrl_fam        (host_wdata[6:5]),
    .ctrl_b0         (host_wdata[0]),
    .ctrl_b3         (host_wdata[3]),
    .core_count      (core_count),
    .core_borrow_evt (core_borrow_evt),
    .core_load       (core_load),
    .core_snap       (core_snap),
    .ptr_idx         (ptr_idx),
    .latch_word      (latch_q),
    .preset_word     (preset_q),
    .flags           (flags),
    .mode_bits       ({cfg_quad_mode, cfg_count_mode, cfg_bcd_en})
);

// File: tb/qc_counter_regif_tb.sv
module qc_counter_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel_ctrl = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [23:0] core_count = '0;
    logic        core_dir_up = 1'b0, core_index_lvl = 1'b0;
    logic [4:0]  evt = '0;
    logic        core_load, core_snap;
    logic [23:0] core_load_value;
    logic        cfg_bcd_en, cfg_ab_en, cfg_idx_preset_off, cfg_idx_en, cfg_idx_pos;
    logic [1:0]  cfg_count_mode, cfg_quad_mode, cfg_aux_sel;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    qc_counter_regif u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_sel_ctrl(host_sel_ctrl), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_count(core_count), .core_dir_up(core_dir_up), .core_index_lvl(core_index_lvl),
        .core_borrow_evt(evt[0]), .core_carry_evt(evt[1]), .core_compare_evt(evt[2]),
        .core_sign_evt(evt[3]), .core_error_evt(evt[4]),
        .core_load(core_load), .core_load_value(core_load_value), .core_snap(core_snap),
        .cfg_bcd_en(cfg_bcd_en), .cfg_count_mode(cfg_count_mode), .cfg_quad_mode(cfg_quad_mode),
        .cfg_ab_en(cfg_ab_en), .cfg_idx_preset_off(cfg_idx_preset_off), .cfg_aux_sel(cfg_aux_sel),
        .cfg_idx_en(cfg_idx_en), .cfg_idx_pos(cfg_idx_pos)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] b);
        @(negedge clk);
        host_sel_ctrl = sel; host_wr = 1'b1; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        @(negedge clk);
        host_sel_ctrl = sel; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    function automatic logic [9:0] cfg_mode();
        return {cfg_quad_mode, cfg_count_mode, cfg_bcd_en, 5'b0};
    endfunction

    function automatic logic [4:0] cfg_io();
        return {cfg_aux_sel, 1'b0, cfg_idx_preset_off, cfg_ab_en};
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        chk("R1", "config outputs", {cfg_bcd_en, cfg_count_mode, cfg_quad_mode, cfg_ab_en,
            cfg_idx_preset_off, cfg_aux_sel, cfg_idx_en, cfg_idx_pos}, 0);
        chk("R1", "load strobe", core_load, 0);
        chk("R1", "preset", core_load_value, 0);
        rd(1'b1, v); chk("R1", "status", v, 8'h00);
        rd(1'b0, v); chk("R1", "latch byte0", v, 8'h00);
    endtask

    task automatic t_preset();
        wr(1'b1, 8'h01);
        wr(1'b0, 8'hC3); wr(1'b0, 8'hB2); wr(1'b0, 8'hA1);
        wr(1'b1, 8'h08);
        chk("R6", "load high", core_load, 1);
        chk("R2", "preset lsb first", core_load_value, 24'hA1B2C3);
        @(negedge clk);
        chk("R6", "load one cycle", core_load, 0);
        wr(1'b0, 8'h55);
        wr(1'b1, 8'h08);
        chk("R2", "wrap to byte0", core_load_value, 24'hA1B255);
    endtask

    task automatic t_snapshot();
        logic [7:0] v;
        core_count = 24'h123456;
        wr(1'b1, 8'h11);
        chk("R5", "snap pulse", core_snap, 1);
        core_count = 24'hFFFFFF;
        rd(1'b0, v); chk("R3", "latch byte0", v, 8'h56);
        rd(1'b0, v); chk("R3", "latch byte1", v, 8'h34);
        rd(1'b0, v); chk("R3", "latch byte2", v, 8'h12);
        rd(1'b0, v); chk("R3", "read wrap", v, 8'h56);
        chk("R3", "no load on read", core_load, 0);
        chk("R3", "preset kept", core_load_value, 24'hA1B255);
        core_count = 24'h0A0B0C;
        wr(1'b1, 8'h10);
        rd(1'b0, v); chk("R5", "0x10 keeps pointer", v, 8'h0B);
    endtask

    task automatic t_rewind();
        logic [7:0] v;
        wr(1'b1, 8'h01);
        rd(1'b0, v); chk("R4", "rewind to byte0", v, 8'h0C);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        pulse(5'h1F);
        rd(1'b1, v); chk("R7", "all flags set", v, 8'h1F);
        wr(1'b1, 8'h02);
        rd(1'b1, v); chk("R7", "0x02 clears status", v, 8'h10);
        pulse(5'h1F);
        wr(1'b1, 8'h06);
        rd(1'b1, v); chk("R7", "0x06 clears error", v, 8'h0F);
        wr(1'b1, 8'h04);
        rd(1'b1, v); chk("R7", "0x04 clears status", v, 8'h00);
        @(negedge clk);
        evt = 5'h01; host_sel_ctrl = 1'b1; host_wr = 1'b1; host_wdata = 8'h02;
        @(negedge clk);
        evt = '0; host_wr = 1'b0;
        rd(1'b1, v); chk("R7", "set beats clear", v, 8'h01);
        wr(1'b1, 8'h02);
    endtask

    task automatic t_status();
        logic [7:0] v;
        core_dir_up = 1'b1;
        rd(1'b1, v); chk("R8", "direction bit5", v, 8'h20);
        core_dir_up = 1'b0; core_index_lvl = 1'b1;
        rd(1'b1, v); chk("R8", "index bit6", v, 8'h40);
        core_dir_up = 1'b1;
        rd(1'b1, v); chk("R8", "both", v, 8'h60);
        core_dir_up = 1'b0; core_index_lvl = 1'b0;
    endtask

    task automatic t_mode();
        wr(1'b1, 8'h3B);
        chk("R9", "mode 0x3B", cfg_mode(), {2'b11, 2'b01, 1'b1, 5'b0});
        wr(1'b1, 8'h24);
        chk("R9", "mode 0x24", cfg_mode(), {2'b00, 2'b10, 1'b0, 5'b0});
        chk("R9", "io untouched", cfg_io(), 0);
    endtask

    task automatic t_ioctl();
        wr(1'b1, 8'h5F);
        chk("R10", "ioctl 0x5F", cfg_io(), {2'b11, 1'b0, 1'b1, 1'b1});
        chk("R9", "mode kept", cfg_mode(), {2'b00, 2'b10, 1'b0, 5'b0});
        wr(1'b1, 8'h4A);
        chk("R10", "ioctl 0x4A", cfg_io(), {2'b01, 1'b0, 1'b1, 1'b0});
    endtask

    task automatic t_index();
        wr(1'b1, 8'h63);
        chk("R11", "index 0x63", {cfg_idx_en, cfg_idx_pos}, 2'b11);
        wr(1'b1, 8'h62);
        chk("R11", "index 0x62", {cfg_idx_en, cfg_idx_pos}, 2'b01);
        wr(1'b1, 8'hE1);
        chk("R12", "bit7 ignored", {cfg_idx_en, cfg_idx_pos}, 2'b10);
    endtask

    task automatic t_no_shift();
        logic [7:0] v;
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h77);
        rd(1'b1, v);
        wr(1'b1, 8'h20);
        wr(1'b0, 8'h88);
        wr(1'b1, 8'h08);
        chk("R12", "pointer and preset unmoved", core_load_value, 24'hA18877);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_preset();
        t_snapshot();
        t_rewind();
        t_flags();
        t_status();
        t_mode();
        t_ioctl();
        t_index();
        t_no_shift();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule